// File: doc/BRIEF.md
# Protected Three-Stage Clock Prescaler

This block takes one fast source clock and produces three slower rates as single-cycle enable pulses in the source domain. The pulses are named by their relation to the slowest rate: a 4x rate, a 2x rate and a 1x rate. They come from a chain of three counters. The first stage divides the source clock and gives the 4x rate. The second stage divides the 4x rate and gives the 2x rate. The third stage divides the 2x rate and gives the 1x rate, which is the one a CPU and most peripherals run on. Because every stage advances only on the pulse of the stage before it, a 1x pulse always coincides with a 2x pulse and a 4x pulse.

One 7-bit setting register holds the divider codes. It is reached through a small synchronous bus. A write to it only lands if a key write opened a short unlock window just before it. A separate lock register can freeze the setting until reset. A new setting that has been stored waits for the next 1x pulse before the counters use it. Each 1x period therefore ends with the timing it started with.

Top module: `pclk_ratio_chain`

## Requirements
- R1: After reset the setting register reads 0 and the lock register reads 0. All three pulses are then asserted on every source cycle, because every divider is 1.
- R2: The first-stage divider comes from setting bits [6:2]. Code 0 gives 1. Codes 1, 3, 5, 7, 9, 11, 13, 15 and 17 give 2, 4, 8, 16, 32, 64, 128, 256 and 512. Codes 19, 21, 23, 25 and 27 give 6, 10, 12, 24 and 48. The 4x pulse repeats every that many source cycles.
- R3: Setting bits [1:0] choose the second and third dividers as a pair. Code 0 gives 1 and 1, code 1 gives 1 and 2, code 2 gives 4 and 1, and code 3 gives 2 and 2.
- R4: A write to the setting register (address 1) that is not inside an unlock window leaves the stored setting and the outputs unchanged.
- R5: Writing 0xD8 to the key register (address 0) opens a window that covers the next 4 source cycles. A setting write in any of those cycles lands. A setting write in the 5th cycle does not. Any other bus write, including another setting write, closes the window.
- R6: Writing 1 to bit 0 of the lock register (address 2) sets a lock that only reset clears. While it is set, setting writes are ignored even inside an unlock window. The lock register reads back the lock in bit 0.
- R7: A first-stage code that is not listed in R2 divides by 1. The setting register still reads back the raw 7 bits that were written.
- R8: A stored setting is applied only at a 1x pulse. The 1x period in progress when the write lands keeps the old timing.
- R9: Every 1x pulse coincides with a 2x pulse, and every 2x pulse coincides with a 4x pulse.
- R10: With first-stage code 0 and pair code 3, the 4x, 2x and 1x pulses repeat every 1, 2 and 4 source cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0 key, 1 setting, 2 lock |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tick_4x | output | 1 | Enable pulse after the first stage |
| tick_2x | output | 1 | Enable pulse after the second stage |
| tick_1x | output | 1 | Enable pulse after the third stage |

## Verification
The hardest case to reach from the ports is a setting change that lands in the middle of a long 1x period. The bench first sets a 64-cycle period and synchronises on a 1x pulse. Within the next two cycles it writes the key and then a one-cycle setting. It then requires the next 1x pulse to arrive exactly 64 cycles after the sync point, which proves that the old timing was kept. The unlock window edges are reached by counting idle cycles between the key write and the setting write. Three and four idle cycles put the setting write in the last cycle of the window and in the first cycle after it.

// File: rtl/pclk_ratio_pkg.sv
package pclk_ratio_pkg;
  localparam int RW        = 10;       // ratio width, holds 512
  localparam int CFG_W     = 7;
  localparam int SEL_LSB   = 2;        // first-stage code position
  localparam int SEL_W     = 5;
  localparam logic [1:0] ADDR_KEY  = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_LOCK = 2'd2;
  localparam logic [7:0] KEY_VAL   = 8'hD8;

  function automatic logic [RW-1:0] first_ratio(input logic [SEL_W-1:0] code);
    case (code)
      5'd1:    first_ratio = RW'(2);
      5'd3:    first_ratio = RW'(4);
      5'd5:    first_ratio = RW'(8);
      5'd7:    first_ratio = RW'(16);
      5'd9:    first_ratio = RW'(32);
      5'd11:   first_ratio = RW'(64);
      5'd13:   first_ratio = RW'(128);
      5'd15:   first_ratio = RW'(256);
      5'd17:   first_ratio = RW'(512);
      5'd19:   first_ratio = RW'(6);
      5'd21:   first_ratio = RW'(10);
      5'd23:   first_ratio = RW'(12);
      5'd25:   first_ratio = RW'(24);
      5'd27:   first_ratio = RW'(48);
      default: first_ratio = RW'(1);
    endcase
  endfunction

  function automatic logic [RW-1:0] second_ratio(input logic [1:0] pair);
    case (pair)
      2'd2:    second_ratio = RW'(4);
      2'd3:    second_ratio = RW'(2);
      default: second_ratio = RW'(1);
    endcase
  endfunction

  function automatic logic [RW-1:0] third_ratio(input logic [1:0] pair);
    third_ratio = pair[0] ? RW'(2) : RW'(1);
  endfunction
endpackage

// File: rtl/pclk_stage.sv
module pclk_stage #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] ratio,
  output logic          term
);
  logic [CW-1:0] cnt;

  assign term = step && (cnt == ratio - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (term) cnt <= '0;
    else if (step) cnt <= cnt + CW'(1);
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < ratio);
endmodule

// File: rtl/pclk_regs.sv
module pclk_regs
  import pclk_ratio_pkg::*;
#(
  parameter int WIN_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic             cfg_write_ok
);
  localparam int WB = $clog2(WIN_LEN + 1);

  logic [WB-1:0] win_cnt;
  logic          locked;
  logic          key_write;
  logic          win_open;

  assign key_write    = bus_we && bus_addr == ADDR_KEY && bus_wdata == KEY_VAL;
  assign win_open     = win_cnt != '0;
  assign cfg_write_ok = bus_we && bus_addr == ADDR_CFG && win_open && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n)        win_cnt <= '0;
    else if (key_write) win_cnt <= WB'(WIN_LEN);
    else if (bus_we)   win_cnt <= '0;
    else if (win_open) win_cnt <= win_cnt - WB'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            cfg_q <= '0;
    else if (cfg_write_ok) cfg_q <= bus_wdata[CFG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) locked <= 1'b0;
    else if (bus_we && bus_addr == ADDR_LOCK && bus_wdata[0]) locked <= 1'b1;
  end

  always_comb begin
    case (bus_addr)
      ADDR_CFG:  bus_rdata = {{(8-CFG_W){1'b0}}, cfg_q};
      ADDR_LOCK: bus_rdata = {7'b0, locked};
      default:   bus_rdata = 8'h00;
    endcase
  end

  assert_no_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_CFG && !win_open) |=> $stable(cfg_q));
  assert_window_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= WB'(WIN_LEN));
  assert_window_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !key_write) |=> !win_open);
  assert_lock_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(cfg_q));
  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
endmodule

// File: rtl/pclk_ratio_chain.sv
module pclk_ratio_chain
  import pclk_ratio_pkg::*;
#(
  parameter int WIN_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       tick_4x,
  output logic       tick_2x,
  output logic       tick_1x
);
  localparam int NSTAGE = 3;

  logic [CFG_W-1:0]  cfg_q;
  logic [CFG_W-1:0]  cfg_act;
  logic              cfg_write_ok;
  logic [NSTAGE-1:0] step;
  logic [NSTAGE-1:0] term;
  logic [RW-1:0]     ratio [NSTAGE];

  pclk_regs #(.WIN_LEN(WIN_LEN)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_q(cfg_q),
    .cfg_write_ok(cfg_write_ok)
  );

  // the stored setting takes effect only at a period boundary
  always_ff @(posedge clk) begin
    if (!rst_n)       cfg_act <= '0;
    else if (tick_1x) cfg_act <= cfg_q;
  end

  assign ratio[0] = first_ratio(cfg_act[SEL_LSB +: SEL_W]);
  assign ratio[1] = second_ratio(cfg_act[1:0]);
  assign ratio[2] = third_ratio(cfg_act[1:0]);
  assign step[0]  = 1'b1;

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    if (i > 0) begin : g_link
      assign step[i] = term[i-1];
    end
    pclk_stage #(.CW(RW)) stage_i (
      .clk(clk), .rst_n(rst_n), .step(step[i]), .ratio(ratio[i]), .term(term[i])
    );
  end

  assign tick_4x = term[0];
  assign tick_2x = term[1];
  assign tick_1x = term[2];

  assert_apply_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_1x |=> $stable(cfg_act));
  assert_align_1x_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1x |-> (tick_2x && tick_4x));
  assert_align_2x_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_2x |-> tick_4x);
endmodule

// File: tb/pclk_ratio_chain_tb_top.sv
module pclk_ratio_chain_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tick_4x, tick_2x, tick_1x;

  int checks = 0;
  int errors = 0;

  typedef struct { string req; int val; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  pclk_ratio_chain dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_4x(tick_4x), .tick_2x(tick_2x), .tick_1x(tick_1x)
  );

  // expected dividers, derived from the requirement tables
  function automatic int div_a(int code);
    if (code == 0) return 1;
    if (code % 2 == 1 && code <= 17) return 1 << ((code + 1) / 2);
    case (code)
      19: return 6;
      21: return 10;
      23: return 12;
      25: return 24;
      27: return 48;
      default: return 1;
    endcase
  endfunction
  function automatic int div_b(int pair);
    int t[4] = '{1, 1, 4, 2};
    return t[pair];
  endfunction
  function automatic int div_c(int pair);
    return (pair == 1 || pair == 3) ? 2 : 1;
  endfunction

  // scoreboard: driver pushes, monitor pops and compares
  task automatic push_exp(string req, int val);
    exp_q.push_back('{req, val});
  endtask
  task automatic pop_cmp(int actual);
    exp_t e;
    e = exp_q.pop_front();
    checks++;
    if (actual != e.val) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", e.req, actual, e.val);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic rd_check(string req, logic [1:0] a, int expv);
    bus_addr = a;
    #1;
    push_exp(req, expv);
    pop_cmp(int'(bus_rdata));
  endtask
  task automatic set_cfg(int code, int pair);
    wr(2'd0, 8'hD8);
    wr(2'd1, 8'((code << 2) | pair));
  endtask

  // sync on a 1x pulse, then observe one full new period
  task automatic measure(string req, int code, int pair);
    int a = div_a(code);
    int b = div_b(pair);
    int c = div_c(pair);
    int cyc = 0, n4 = 0, n2 = 0, first4 = 0, mis = 0;
    bit done = 0;
    while (!tick_1x) @(negedge clk);
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (tick_4x) begin n4++; if (first4 == 0) first4 = cyc; end
      if (tick_2x) n2++;
      if ((tick_1x && !tick_2x) || (tick_2x && !tick_4x)) mis++;
      if (tick_1x || cyc > 5000) done = 1;
    end
    push_exp({req, " 1x period"}, a * b * c);
    push_exp({req, " first 4x (R2)"}, a);
    push_exp({req, " 4x per 1x (R3)"}, b * c);
    push_exp({req, " 2x per 1x (R3)"}, c);
    push_exp("R9 alignment", 0);
    pop_cmp(cyc); pop_cmp(first4); pop_cmp(n4); pop_cmp(n2); pop_cmp(mis);
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd_check("R1 cfg reset", 2'd1, 0);
    rd_check("R1 lock reset", 2'd2, 0);
    measure("R1", 0, 0);
    // R4 write without key
    wr(2'd1, 8'h03);
    rd_check("R4 no key", 2'd1, 0);
    measure("R4", 0, 0);
    // R10 example
    set_cfg(0, 3);
    rd_check("R10 readback", 2'd1, 3);
    measure("R10", 0, 3);
    // R2 / R3 table points
    set_cfg(1, 1);  measure("R2 code1", 1, 1);
    set_cfg(7, 0);  measure("R2 code7", 7, 0);
    set_cfg(19, 3); measure("R2 code19", 19, 3);
    set_cfg(27, 1); measure("R2 code27", 27, 1);
    set_cfg(17, 2); measure("R2 code17", 17, 2);
    set_cfg(23, 2); measure("R3 pair2", 23, 2);
    // R7 unlisted codes
    set_cfg(4, 3);
    rd_check("R7 raw readback", 2'd1, (4 << 2) | 3);
    measure("R7 code4", 4, 3);
    set_cfg(31, 0);
    rd_check("R7 raw readback 31", 2'd1, 31 << 2);
    measure("R7 code31", 31, 0);
    // R5 window edges
    wr(2'd0, 8'hD8); idle(3); wr(2'd1, 8'h01);
    rd_check("R5 last window cycle", 2'd1, 1);
    wr(2'd0, 8'hD8); idle(4); wr(2'd1, 8'h02);
    rd_check("R5 after window", 2'd1, 1);
    wr(2'd0, 8'hD8); wr(2'd1, 8'h03); wr(2'd1, 8'h02);
    rd_check("R5 second write closed", 2'd1, 3);
    wr(2'd0, 8'hD8); wr(2'd0, 8'h00); wr(2'd1, 8'h02);
    rd_check("R5 other write closes", 2'd1, 3);
    // R8 mid-period change keeps old period
    set_cfg(7, 3);
    measure("R8 setup", 7, 3);
    wr(2'd0, 8'hD8);
    wr(2'd1, 8'h00);
    k = 2;
    while (!tick_1x && k < 5000) begin @(negedge clk); k++; end
    push_exp("R8 old period kept", 64);
    pop_cmp(k);
    measure("R8 new", 0, 0);
    // R6 lock
    set_cfg(3, 1);
    wr(2'd2, 8'h01);
    rd_check("R6 lock readback", 2'd2, 1);
    set_cfg(9, 2);
    rd_check("R6 locked cfg", 2'd1, (3 << 2) | 1);
    measure("R6 locked timing", 3, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule